// File: doc/BRIEF.md
# Bus Prescaler with Timer Clock Doubling

This block turns one system clock into a chain of clock-enable pulses for a three-level bus tree. A programmable core-bus divider runs directly on the system clock. Two peripheral-bus dividers, a low-speed one and a high-speed one, each count pulses of the core-bus enable. Everything stays in the system clock domain. A consumer on any bus advances only in cycles where its enable is high.

Each peripheral bus also gets a timer enable. It equals the bus enable while that bus is undivided. Once the bus is divided, the timer enable runs at twice the bus rate, so timers on a slowed bus keep twice the bus rate.

Software writes new divider codes with a write strobe. Each divider switches to its new ratio only at the end of its current period. A limit flag reports when the active settings would run the low-speed bus above half of the maximum core-bus rate.

Top module: `bus_prescaler`

## Requirements
- R1: The core-bus enable `core_en` pulses for one cycle once every 2^c system cycles, where c is the active 3-bit core code. With c = 0 it stays high every cycle.
- R2: Each peripheral bus (`slow_*`, `fast_*`) has a 2-bit code p with ratio 2^p (codes 0..3 give 1, 2, 4, 8). It counts core-bus pulses, so its bus enable pulses once every 2^c * 2^p system cycles. Every bus pulse coincides with a core-bus pulse.
- R3: When a peripheral bus code is 0, its timer enable is identical to its bus enable in every cycle.
- R4: When a peripheral bus code is not 0, its timer enable pulses twice per bus period, evenly spaced. One of the two pulses is in the bus-enable cycle, and every timer pulse coincides with a core-bus pulse.
- R5: `slow_over_limit` is high exactly when 2 * SYS_MHZ > MAX_CORE_MHZ * 2^c * 2^p_slow for the active codes. With the defaults (72, 72) this holds only when both the core code and the low-speed code are 0.
- R6: All three codes are captured from the input fields in a cycle with `cfg_wr` high. A captured code becomes active only after the cycle in which that divider's current period ends, so no period is ever shortened.
- R7: After reset every counter is zero and the active codes are core 0, high-speed 0, low-speed 1 (divide by 2). The first low-speed pulse therefore appears in the second cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Capture strobe for the three code fields |
| cfg_core_sel | input | 3 | Core-bus code c, ratio 2^c |
| cfg_slow_sel | input | 2 | Low-speed bus code, ratio 2^p |
| cfg_fast_sel | input | 2 | High-speed bus code, ratio 2^p |
| core_en | output | 1 | Core-bus clock enable |
| slow_en | output | 1 | Low-speed bus clock enable |
| fast_en | output | 1 | High-speed bus clock enable |
| slow_tmr_en | output | 1 | Timer enable for the low-speed bus |
| fast_tmr_en | output | 1 | Timer enable for the high-speed bus |
| slow_over_limit | output | 1 | Low-speed bus rate above half of the maximum core rate |

## Verification
The assertions check the per-cycle relations on every cycle:
- a bus or timer pulse only coincides with a core pulse;
- a bus pulse is always also a timer pulse;
- the timer equals the bus on an undivided bus;
- the core enable is held high at ratio 1;
- an active code changes only right after that divider's period-end cycle.

Only the bench scenarios can show the rates themselves. They count pulses over windows that are whole multiples of every period, across many code combinations. Covered this way are the doubled timer counts, the limit flag's value, the reset ratios, and the exact eight-cycle gap when a code is rewritten in the middle of a period.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Divide ratio selected by a code: 2^code.
  function automatic int div_ratio(input int code);
    return 1 << code;
  endfunction

  // Low-speed bus too fast: its rate would exceed half of the maximum core rate.
  function automatic logic slow_too_fast(input int sys_mhz, input int max_mhz,
                                         input int core_code, input int slow_code);
    return (2 * sys_mhz) > (max_mhz * (1 << (core_code + slow_code)));
  endfunction

endpackage

// File: rtl/bp_core_div.sv
module bp_core_div #(
  parameter int SEL_W   = 3,
  parameter int RST_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel_wr,
  output logic             tick_out,
  output logic [SEL_W-1:0] act_sel
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] pend_q, act_q, pend_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             period_end;

  assign pend_nxt   = wr ? sel_wr : pend_q;
  assign period_end = (cnt_q == CNT_W'(bp_pkg::div_ratio(int'(act_q)) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= SEL_W'(RST_SEL);
      act_q  <= SEL_W'(RST_SEL);
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (period_end) begin
        cnt_q <= '0;
        act_q <= pend_nxt;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign tick_out = period_end;
  assign act_sel  = act_q;
endmodule

// File: rtl/bp_bus_div.sv
module bp_bus_div #(
  parameter int SEL_W   = 2,
  parameter int RST_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel_wr,
  output logic             bus_en,
  output logic             tmr_en,
  output logic [SEL_W-1:0] act_sel
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] pend_q, act_q, pend_nxt;
  logic [CNT_W-1:0] cnt_q, last_cnt, half_cnt;
  logic             at_last, at_half;

  assign pend_nxt = wr ? sel_wr : pend_q;
  assign last_cnt = CNT_W'(bp_pkg::div_ratio(int'(act_q)) - 1);
  assign half_cnt = CNT_W'(bp_pkg::div_ratio(int'(act_q)) / 2 - 1);
  assign at_last  = tick_in && (cnt_q == last_cnt);
  assign at_half  = tick_in && (act_q != '0) && (cnt_q == half_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= SEL_W'(RST_SEL);
      act_q  <= SEL_W'(RST_SEL);
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (at_last) begin
        cnt_q <= '0;
        act_q <= pend_nxt;
      end else if (tick_in) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign bus_en  = at_last;
  assign tmr_en  = at_last | at_half;
  assign act_sel = act_q;
endmodule

// File: rtl/bp_limit_chk.sv
module bp_limit_chk #(
  parameter int CORE_SEL_W   = 3,
  parameter int BUS_SEL_W    = 2,
  parameter int SYS_MHZ      = 72,
  parameter int MAX_CORE_MHZ = 72
) (
  input  logic [CORE_SEL_W-1:0] core_sel,
  input  logic [BUS_SEL_W-1:0]  slow_sel,
  output logic                  over
);
  always_comb begin
    over = bp_pkg::slow_too_fast(SYS_MHZ, MAX_CORE_MHZ, int'(core_sel), int'(slow_sel));
  end
endmodule

// File: rtl/bus_prescaler.sv
module bus_prescaler #(
  parameter int CORE_SEL_W   = 3,
  parameter int BUS_SEL_W    = 2,
  parameter int SYS_MHZ      = 72,
  parameter int MAX_CORE_MHZ = 72,
  parameter int RST_CORE_SEL = 0,
  parameter int RST_SLOW_SEL = 1,
  parameter int RST_FAST_SEL = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [CORE_SEL_W-1:0] cfg_core_sel,
  input  logic [BUS_SEL_W-1:0]  cfg_slow_sel,
  input  logic [BUS_SEL_W-1:0]  cfg_fast_sel,
  output logic                  core_en,
  output logic                  slow_en,
  output logic                  fast_en,
  output logic                  slow_tmr_en,
  output logic                  fast_tmr_en,
  output logic                  slow_over_limit
);
  localparam int NBUS = 2;            // index 0: low-speed, index 1: high-speed
  localparam int BUS_RST [NBUS] = '{RST_SLOW_SEL, RST_FAST_SEL};

  logic [CORE_SEL_W-1:0] core_sel_act;
  logic [BUS_SEL_W-1:0]  bus_sel_wr  [NBUS];
  logic [BUS_SEL_W-1:0]  bus_sel_act [NBUS];
  logic                  bus_tick    [NBUS];
  logic                  bus_tmr     [NBUS];

  assign bus_sel_wr[0] = cfg_slow_sel;
  assign bus_sel_wr[1] = cfg_fast_sel;

  bp_core_div #(.SEL_W(CORE_SEL_W), .RST_SEL(RST_CORE_SEL)) u_core (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel_wr(cfg_core_sel),
    .tick_out(core_en), .act_sel(core_sel_act)
  );

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    bp_bus_div #(.SEL_W(BUS_SEL_W), .RST_SEL(BUS_RST[g])) u_bus (
      .clk(clk), .rst_n(rst_n), .tick_in(core_en), .wr(cfg_wr),
      .sel_wr(bus_sel_wr[g]), .bus_en(bus_tick[g]), .tmr_en(bus_tmr[g]),
      .act_sel(bus_sel_act[g])
    );
  end

  // Named event wires for the bound checker
  logic [BUS_SEL_W-1:0] slow_sel_act, fast_sel_act;
  assign slow_sel_act = bus_sel_act[0];
  assign fast_sel_act = bus_sel_act[1];

  assign slow_en     = bus_tick[0];
  assign fast_en     = bus_tick[1];
  assign slow_tmr_en = bus_tmr[0];
  assign fast_tmr_en = bus_tmr[1];

  bp_limit_chk #(.CORE_SEL_W(CORE_SEL_W), .BUS_SEL_W(BUS_SEL_W),
                 .SYS_MHZ(SYS_MHZ), .MAX_CORE_MHZ(MAX_CORE_MHZ)) u_lim (
    .core_sel(core_sel_act), .slow_sel(slow_sel_act), .over(slow_over_limit)
  );
endmodule

// File: rtl/bus_prescaler_chk.sv
module bus_prescaler_chk #(
  parameter int CORE_SEL_W = 3,
  parameter int BUS_SEL_W  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  core_en,
  input logic                  slow_en,
  input logic                  fast_en,
  input logic                  slow_tmr_en,
  input logic                  fast_tmr_en,
  input logic [CORE_SEL_W-1:0] core_sel_act,
  input logic [BUS_SEL_W-1:0]  slow_sel_act,
  input logic [BUS_SEL_W-1:0]  fast_sel_act
);
  // R1
  core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_sel_act == '0) |-> core_en);
  // R2
  bus_on_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_en || fast_en) |-> core_en);
  // R4
  tmr_on_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_tmr_en || fast_tmr_en) |-> core_en);
  // R4
  bus_is_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_en |-> slow_tmr_en) and (fast_en |-> fast_tmr_en));
  // R3
  slow_undiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_sel_act == '0) |-> (slow_tmr_en == slow_en));
  // R3
  fast_undiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_sel_act == '0) |-> (fast_tmr_en == fast_en));
  // R6
  slow_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slow_sel_act) |-> $past(slow_en));
  // R6
  fast_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fast_sel_act) |-> $past(fast_en));
  // R6
  core_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_sel_act) |-> $past(core_en));
endmodule

bind bus_prescaler bus_prescaler_chk #(.CORE_SEL_W(CORE_SEL_W), .BUS_SEL_W(BUS_SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .slow_en(slow_en), .fast_en(fast_en),
  .slow_tmr_en(slow_tmr_en), .fast_tmr_en(fast_tmr_en), .core_sel_act(core_sel_act),
  .slow_sel_act(slow_sel_act), .fast_sel_act(fast_sel_act)
);

// File: tb/bus_prescaler_tb.sv
module bus_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_core_sel = '0;
  logic [1:0] cfg_slow_sel = 2'd1;
  logic [1:0] cfg_fast_sel = '0;
  logic core_en, slow_en, fast_en, slow_tmr_en, fast_tmr_en, slow_over_limit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  bus_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_core_sel(cfg_core_sel),
    .cfg_slow_sel(cfg_slow_sel), .cfg_fast_sel(cfg_fast_sel), .core_en(core_en),
    .slow_en(slow_en), .fast_en(fast_en), .slow_tmr_en(slow_tmr_en),
    .fast_tmr_en(fast_tmr_en), .slow_over_limit(slow_over_limit)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic write_cfg(input int c, input int s, input int f);
    @(negedge clk);
    cfg_core_sel = 3'(c); cfg_slow_sel = 2'(s); cfg_fast_sel = 2'(f);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic count_window(input int w, output int nc, output int ns, output int nf,
                              output int nst, output int nft);
    nc = 0; ns = 0; nf = 0; nst = 0; nft = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      nc += int'(core_en); ns += int'(slow_en); nf += int'(fast_en);
      nst += int'(slow_tmr_en); nft += int'(fast_tmr_en);
    end
  endtask

  // R7: state straight after reset
  task automatic t_reset();
    int nc, ns, nf, nst, nft;
    check(core_en == 1'b1, "R7 core_en first cycle", int'(core_en), 1);
    check(slow_en == 1'b0, "R7 slow_en first cycle", int'(slow_en), 0);
    check(fast_en == 1'b1, "R7 fast_en first cycle", int'(fast_en), 1);
    check(slow_over_limit == 1'b0, "R7 limit flag at reset", int'(slow_over_limit), 0);
    @(negedge clk);
    check(slow_en == 1'b1, "R7 slow_en second cycle", int'(slow_en), 1);
    count_window(64, nc, ns, nf, nst, nft);
    check(ns == 32, "R7 slow count div2", ns, 32);
    check(nst == 64, "R4 slow timer doubled at reset", nst, 64);
  endtask

  // R1 R2 R3 R4 R5: window counts for one combination
  task automatic t_combo(input int c, input int s, input int f, input int settle, input int w);
    int nc, ns, nf, nst, nft, rc, rs, rf;
    bit exp_over;
    write_cfg(c, s, f);
    repeat (settle) @(negedge clk);
    count_window(w, nc, ns, nf, nst, nft);
    rc = 1 << c; rs = rc * (1 << s); rf = rc * (1 << f);
    check(nc == w / rc, $sformatf("R1 core c=%0d", c), nc, w / rc);
    check(ns == w / rs, $sformatf("R2 slow c=%0d s=%0d", c, s), ns, w / rs);
    check(nf == w / rf, $sformatf("R2 fast c=%0d f=%0d", c, f), nf, w / rf);
    check(nst == ((s == 0) ? 1 : 2) * (w / rs),
          $sformatf("R3/R4 slow timer c=%0d s=%0d", c, s), nst, ((s == 0) ? 1 : 2) * (w / rs));
    check(nft == ((f == 0) ? 1 : 2) * (w / rf),
          $sformatf("R3/R4 fast timer c=%0d f=%0d", c, f), nft, ((f == 0) ? 1 : 2) * (w / rf));
    exp_over = (2 * 72) > (72 * rs);
    check(slow_over_limit == exp_over, $sformatf("R5 limit c=%0d s=%0d", c, s),
          int'(slow_over_limit), int'(exp_over));
  endtask

  // R6: rewrite mid-period must not shorten the running period
  task automatic t_boundary();
    int n;
    write_cfg(0, 3, 0);
    repeat (2200) @(negedge clk);
    n = 0;
    while (slow_en !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 3) begin
        cfg_core_sel = '0; cfg_slow_sel = 2'd0; cfg_fast_sel = '0; cfg_wr = 1'b1;
      end else begin
        cfg_wr = 1'b0;
      end
    end while (slow_en !== 1'b1 && n < 100);
    check(n == 8, "R6 period kept after mid-period write", n, 8);
    @(negedge clk);
    check(slow_en == 1'b1, "R6 new ratio after boundary", int'(slow_en), 1);
    check(slow_tmr_en == slow_en, "R3 timer equals bus undivided", int'(slow_tmr_en), int'(slow_en));
    check(slow_over_limit == 1'b1, "R5 limit with both undivided", int'(slow_over_limit), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < 4; s++)
        t_combo(c, s, 3 - s, 200, 1024);
    t_combo(7, 3, 0, 2200, 2048);
    t_boundary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule